// File: doc/BRIEF.md
# Half-Duplex Line Direction Controller

This block turns a half-duplex RS-485 transceiver around for one UART channel without software help. While the channel transmits, the selected active-low modem pin is held high, which enables the line driver. Once the final character's stop bit has left the wire and the transmit FIFO is empty, the block waits a programmable number of bit times and then drives the pin low, so the transceiver listens for the remote station's reply. The delay gives the last bits time to reach the far end of a long cable before the driver is released.

When the host loads new data, the block raises the pin first and holds the serializer off until at least one baud tick has passed with the pin high. A second active-low pin can carry the direction instead of the first. The other pin, and both pins when the feature is off, keep their normal modem-control levels. While the feature is on, the transmit-empty interrupt source is switched from "FIFO empty" to "shift register empty", so software learns when the last bit has actually gone out.

Top module: `hdx_dir_ctrl`

## Requirements
- R1: While `rst` is high, every rising edge sets `rts_n`=1, `dtr_n`=1, `tx_go`=0 and `txe_src`=1.
- R2: With `en`=0, each edge copies `mc_rts_n` to `rts_n` and `mc_dtr_n` to `dtr_n`, sets `tx_go`=1 and copies `fifo_empty` to `txe_src`.
- R3: With `en`=1 and no transmission pending, the direction pin is low and `tx_go` is 0.
- R4: `tx_req` sampled while in receive drives the direction pin high on that edge. `tx_go` rises on the edge that samples the first `baud_tick` after that edge. A tick sampled together with `tx_req` does not count.
- R5: `stop_done` sampled with `fifo_empty`=1 while transmitting, with `turn_dly`=0, drives the direction pin low and `tx_go` to 0 on that same edge.
- R6: With `turn_dly`=N>0, the direction pin stays high after that stop and falls on the edge that samples the N-th `baud_tick`. `tx_go` stays 1 until then.
- R7: `tx_req` sampled while the turnaround delay runs cancels it. The pin and `tx_go` stay high, and the next qualifying stop restarts the full delay.
- R8: `stop_done` sampled with `fifo_empty`=0 has no effect. The pin and `tx_go` stay high.
- R9: With `en`=1, each edge copies `tsr_empty` to `txe_src`.
- R10: `pin_sel`=0 puts the direction on `rts_n` while `dtr_n` follows `mc_dtr_n`. `pin_sel`=1 puts it on `dtr_n` while `rts_n` follows `mc_rts_n`.
- R11: Clearing `en` during a transmission returns the pins to their modem levels on the next edge. Setting it again starts in receive, with the pin low and `tx_go`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Automatic direction control enable |
| pin_sel | input | 1 | 0: direction on rts_n, 1: direction on dtr_n |
| turn_dly | input | 4 | Turnaround delay in bit times (0..15) |
| fifo_empty | input | 1 | Transmit FIFO empty |
| tsr_empty | input | 1 | Transmit shift register empty |
| stop_done | input | 1 | One-cycle strobe: a stop bit has finished |
| baud_tick | input | 1 | One-cycle strobe once per bit time |
| tx_req | input | 1 | New data has been loaded for transmission |
| mc_rts_n | input | 1 | Modem-control level for rts_n |
| mc_dtr_n | input | 1 | Modem-control level for dtr_n |
| rts_n | output | 1 | RTS pin, active low |
| dtr_n | output | 1 | DTR pin, active low |
| tx_go | output | 1 | Serializer may start sending |
| txe_src | output | 1 | Selected transmit-empty interrupt source |

## Verification
The direction sequence is exercised with a short message that ends in a stop bit while the FIFO still holds data, which separates a true last stop from an intermediate one. It is also exercised with a delay cut short by new data, which shows that a cancelled delay restarts from its full value rather than resuming. Zero, short and maximum delays are compared, so an off-by-one in the tick count shows up as a pin that falls one tick early or late. Each pin choice is tried with modem levels opposite to the direction level, so the pin that carries the direction can be told apart from the pin that merely follows its modem input.

// File: rtl/hdx_pkg.sv
package hdx_pkg;
  typedef enum logic [1:0] {
    ST_RX   = 2'd0,  // line released, receiving
    ST_ARM  = 2'd1,  // driver on, waiting one bit time
    ST_TX   = 2'd2,  // serializer allowed
    ST_HOLD = 2'd3   // turnaround delay running
  } hdx_state_e;

  localparam int HDX_NPIN = 2;  // pin 0: rts_n, pin 1: dtr_n
endpackage

// File: rtl/hdx_turn_timer.sv
module hdx_turn_timer #(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [DLY_W-1:0] dly,
  input  logic             step,
  output logic             last
);
  logic [DLY_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= dly;
    else if (step && cnt != '0)
      cnt <= cnt - DLY_W'(1);
  end

  assign last = (cnt == DLY_W'(1));
endmodule

// File: rtl/hdx_dir_fsm.sv
module hdx_dir_fsm
  import hdx_pkg::*;
#(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DLY_W-1:0] turn_dly,
  input  logic             fifo_empty,
  input  logic             stop_done,
  input  logic             baud_tick,
  input  logic             tx_req,
  output logic             drive_nxt,
  output logic             go_nxt
);
  hdx_state_e st, nxt;
  logic load, last;

  hdx_turn_timer #(.DLY_W(DLY_W)) i_timer (
    .clk  (clk),
    .rst  (rst),
    .load (load),
    .dly  (turn_dly),
    .step (baud_tick && st == ST_HOLD),
    .last (last)
  );

  always_comb begin
    nxt  = st;
    load = 1'b0;
    if (!en) begin
      nxt = ST_RX;
    end else begin
      case (st)
        ST_RX:   if (tx_req) nxt = ST_ARM;
        ST_ARM:  if (baud_tick) nxt = ST_TX;
        ST_TX: begin
          if (stop_done && fifo_empty) begin
            if (turn_dly == '0) begin
              nxt = ST_RX;
            end else begin
              nxt  = ST_HOLD;
              load = 1'b1;
            end
          end
        end
        ST_HOLD: begin
          if (tx_req)
            nxt = ST_TX;
          else if (baud_tick && last)
            nxt = ST_RX;
        end
        default: nxt = ST_RX;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_RX;
    else     st <= nxt;
  end

  assign drive_nxt = (nxt != ST_RX);
  assign go_nxt    = (nxt == ST_TX) || (nxt == ST_HOLD);
endmodule

// File: rtl/hdx_pin_mux.sv
module hdx_pin_mux #(
  parameter int NPIN = 2,
  localparam int SEL_W = (NPIN > 1) ? $clog2(NPIN) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  input  logic             drive,
  input  logic [NPIN-1:0]  mc_n,
  output logic [NPIN-1:0]  pin_n
);
  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst)
        pin_n[i] <= 1'b1;
      else if (en && sel == SEL_W'(i))
        pin_n[i] <= drive;
      else
        pin_n[i] <= mc_n[i];
    end
  end
endmodule

// File: rtl/hdx_dir_ctrl.sv
module hdx_dir_ctrl
  import hdx_pkg::*;
#(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             pin_sel,
  input  logic [DLY_W-1:0] turn_dly,
  input  logic             fifo_empty,
  input  logic             tsr_empty,
  input  logic             stop_done,
  input  logic             baud_tick,
  input  logic             tx_req,
  input  logic             mc_rts_n,
  input  logic             mc_dtr_n,
  output logic             rts_n,
  output logic             dtr_n,
  output logic             tx_go,
  output logic             txe_src
);
  logic drive_nxt, go_nxt;
  logic [HDX_NPIN-1:0] pins;

  hdx_dir_fsm #(.DLY_W(DLY_W)) i_fsm (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .turn_dly   (turn_dly),
    .fifo_empty (fifo_empty),
    .stop_done  (stop_done),
    .baud_tick  (baud_tick),
    .tx_req     (tx_req),
    .drive_nxt  (drive_nxt),
    .go_nxt     (go_nxt)
  );

  hdx_pin_mux #(.NPIN(HDX_NPIN)) i_mux (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .sel   (pin_sel),
    .drive (drive_nxt),
    .mc_n  ({mc_dtr_n, mc_rts_n}),
    .pin_n (pins)
  );

  assign rts_n = pins[0];
  assign dtr_n = pins[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_go   <= 1'b0;
      txe_src <= 1'b1;
    end else begin
      tx_go   <= !en || go_nxt;
      txe_src <= en ? tsr_empty : fifo_empty;
    end
  end
endmodule

// File: rtl/hdx_dir_chk.sv
module hdx_dir_chk (
  input logic clk,
  input logic rst,
  input logic en,
  input logic pin_sel,
  input logic fifo_empty,
  input logic tsr_empty,
  input logic baud_tick,
  input logic tx_req,
  input logic mc_rts_n,
  input logic mc_dtr_n,
  input logic rts_n,
  input logic dtr_n,
  input logic tx_go,
  input logic txe_src
);
  logic up;
  always_ff @(posedge clk) begin
    if (rst) up <= 1'b0;
    else     up <= 1'b1;
  end

  a_r2_modem_follow: assert property (@(posedge clk) disable iff (rst)
    up && !$past(en) |-> rts_n == $past(mc_rts_n) && dtr_n == $past(mc_dtr_n)
                         && tx_go && txe_src == $past(fifo_empty));

  a_r3_rx_no_permit: assert property (@(posedge clk) disable iff (rst)
    up && $past(en) && !$past(pin_sel) && !rts_n |-> !tx_go);

  a_r4_permit_after_tick: assert property (@(posedge clk) disable iff (rst)
    up && $rose(tx_go) && $past(en) |-> $past(baud_tick));

  a_r7_req_keeps_drive: assert property (@(posedge clk) disable iff (rst)
    up && $past(en) && $past(tx_req) && !$past(pin_sel) |-> rts_n);

  a_r9_shift_empty_src: assert property (@(posedge clk) disable iff (rst)
    up && $past(en) |-> txe_src == $past(tsr_empty));

  a_r10_other_pin: assert property (@(posedge clk) disable iff (rst)
    up && $past(en) && !$past(pin_sel) |-> dtr_n == $past(mc_dtr_n));
endmodule

bind hdx_dir_ctrl hdx_dir_chk i_chk (.*);

// File: tb/test_hdx_dir_ctrl.sv
`timescale 1ns/1ps
module test_hdx_dir_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en, pin_sel, fifo_empty, tsr_empty, stop_done, baud_tick, tx_req;
  logic mc_rts_n, mc_dtr_n;
  logic [3:0] turn_dly;
  logic rts_n, dtr_n, tx_go, txe_src;
  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;  // 50 MHz

  hdx_dir_ctrl i_hdx_dir_ctrl (
    .clk(clk), .rst(rst), .en(en), .pin_sel(pin_sel), .turn_dly(turn_dly),
    .fifo_empty(fifo_empty), .tsr_empty(tsr_empty), .stop_done(stop_done),
    .baud_tick(baud_tick), .tx_req(tx_req), .mc_rts_n(mc_rts_n),
    .mc_dtr_n(mc_dtr_n), .rts_n(rts_n), .dtr_n(dtr_n), .tx_go(tx_go),
    .txe_src(txe_src)
  );

  // en_sel_dly_req_tick_stop_fe_te_mr_md _ rts_dtr_go_txe
  localparam int NV = 22;
  localparam logic [16:0] VEC [NV] = '{
    17'b0_0_0010_0_0_0_1_0_1_0_1_0_1_1,  // R2 disabled, pattern A
    17'b0_0_0010_0_0_0_0_1_0_1_0_1_1_0,  // R2 disabled, pattern B
    17'b1_0_0010_0_0_0_1_1_1_0_0_0_0_1,  // R3 idle receive
    17'b1_0_0010_1_1_0_0_1_1_0_1_0_0_1,  // R4 request, same-cycle tick ignored
    17'b1_0_0010_0_0_0_0_0_1_0_1_0_0_0,  // R4 still waiting, R9
    17'b1_0_0010_0_1_0_0_0_1_0_1_0_1_0,  // R4 tick grants permit
    17'b1_0_0010_0_0_1_0_0_1_0_1_0_1_0,  // R8 stop with FIFO not empty
    17'b1_0_0010_0_0_1_1_1_1_0_1_0_1_1,  // R6 last stop, delay 2 starts
    17'b1_0_0010_0_1_0_1_1_1_0_1_0_1_1,  // R6 first tick
    17'b1_0_0010_0_0_0_1_1_1_0_1_0_1_1,  // R6 no tick
    17'b1_0_0010_1_1_0_0_0_1_0_1_0_1_0,  // R7 new data cancels delay
    17'b1_0_0010_0_1_0_0_0_1_0_1_0_1_0,  // R7 transmitting again
    17'b1_0_0010_0_0_1_1_1_1_0_1_0_1_1,  // R7 delay restarts full
    17'b1_0_0010_0_1_0_1_1_1_0_1_0_1_1,  // R7 first tick, still high
    17'b1_0_0010_0_1_0_1_1_1_0_0_0_0_1,  // R6 second tick releases line
    17'b1_0_0000_1_0_0_0_1_1_0_1_0_0_1,  // R4 request with zero delay
    17'b1_0_0000_0_1_0_0_1_1_0_1_0_1_1,  // R4 permit
    17'b1_0_0000_0_0_1_1_1_1_0_0_0_0_1,  // R5 zero delay: immediate release
    17'b1_1_0000_1_0_0_0_1_0_0_0_1_0_1,  // R10 direction on dtr_n
    17'b1_1_0000_0_1_0_0_1_0_0_0_1_1_1,  // R10 permit on dtr_n route
    17'b0_1_0000_0_0_0_1_0_1_1_1_1_1_1,  // R11 disable mid-transmit
    17'b1_1_0000_0_0_0_1_0_1_1_1_0_0_0   // R11 re-enable starts in receive
  };
  localparam int VREQ [NV] = '{2,2,3,4,4,4,8,6,6,6,7,7,7,7,6,4,4,5,10,10,11,11};

  task automatic check(input string tag, input logic [3:0] exp);
    logic [3:0] got;
    got = {rts_n, dtr_n, tx_go, txe_src};
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: {rts_n,dtr_n,tx_go,txe_src} got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic drive(input logic e, s, input logic [3:0] d,
                       input logic rq, tk, sp, f, t);
    en = e; pin_sel = s; turn_dly = d; tx_req = rq; baud_tick = tk;
    stop_done = sp; fifo_empty = f; tsr_empty = t;
  endtask

  initial begin
    drive(0, 0, 4'd0, 0, 0, 0, 1, 1);
    mc_rts_n = 1'b0; mc_dtr_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset values", 4'b1101);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      {en, pin_sel, turn_dly, tx_req, baud_tick, stop_done,
       fifo_empty, tsr_empty, mc_rts_n, mc_dtr_n} = VEC[i][16:4];
      @(negedge clk);
      check($sformatf("R%0d vector %0d", VREQ[i], i), VEC[i][3:0]);
    end

    // R6 at maximum delay, ticks spaced apart
    mc_rts_n = 1'b1; mc_dtr_n = 1'b0;
    drive(1, 0, 4'd15, 1, 0, 0, 0, 0);
    @(negedge clk);
    check("R4 armed before long delay", 4'b1000);
    drive(1, 0, 4'd15, 0, 1, 0, 0, 0);
    @(negedge clk);
    check("R4 permit before long delay", 4'b1010);
    drive(1, 0, 4'd15, 0, 0, 1, 1, 1);
    @(negedge clk);
    check("R6 delay 15 loaded", 4'b1011);
    for (int k = 1; k <= 15; k++) begin
      drive(1, 0, 4'd15, 0, 0, 0, 1, 1);
      repeat (2) @(negedge clk);
      drive(1, 0, 4'd15, 0, 1, 0, 1, 1);
      @(negedge clk);
      if (k == 14) check("R6 high after 14 of 15 ticks", 4'b1011);
      if (k == 15) check("R6 low after tick 15", 4'b0001);
    end

    // R1 reset during an armed request
    drive(1, 0, 4'd3, 1, 0, 0, 0, 0);
    @(negedge clk);
    check("R4 armed before reset", 4'b1000);
    rst = 1'b1;
    drive(1, 0, 4'd3, 0, 1, 0, 0, 0);
    @(negedge clk);
    check("R1 reset overrides transmit", 4'b1101);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule